// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block opens and closes the eight per-class transmission gates of every egress port according to a repeating list of timed entries. A free-running nanosecond time value and a shared base time set the phase, and each port carries its own entry list and cycle length. Each entry holds a class mask and an interval. All ports run on one engine that works in 200 ns slots, so two gate events on different ports that land in the same slot form a schedule conflict. The block reports every such conflict with the set of ports involved.

Software programs a port through a single valid/ready write channel into a shadow copy of its list, then commits it. A port that is not yet running takes the committed list at once and starts at the base time. A port that is already running swaps to the new list at its next cycle boundary. While any commit waits for its swap, `cfg_ready` stays low. The writer must then hold `cfg_valid` and its payload stable until it sees `cfg_ready` high at a clock edge. A beat is taken only on an edge where both are high.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and for any port that has no committed schedule or whose start edge has not come (a port starts at the first clock edge where `time_ns >= base_ns`), all eight gates of that port read 1. After reset `cfg_ready` is 1, and `cfg_err`, `sched_conflict` and `conflict_ports` are 0.
- R2: Bit n of the active entry's mask drives `gate_open[p*8+n]`, so that bit opens class n of port p.
- R3: Entries run in index order from the start of each cycle. Entry j ends after its interval, and each change shows at the first clock edge where `time_ns` has reached the event time.
- R4: The cycle restarts at entry 0 every cycle time after the base time. If the entry intervals sum to less than the cycle, the last entry stays open until the boundary. If they sum to more, the entries that would pass the boundary are cut short or skipped.
- R5: Interval and cycle values given in ns are rounded to slots as floor((ns+100)/200). `cfg_op`=0 writes entry `cfg_idx` with mask `cfg_mask` and interval `cfg_ns`. `cfg_op`=1 sets the last used entry index to `cfg_idx` and the cycle time to `cfg_ns`.
- R6: A `cfg_op` 0 or 1 write that rounds to zero slots is dropped and leaves the shadow list unchanged. `cfg_err` is 1 for exactly the cycle after that write is taken, and is 0 at all other times.
- R7: `cfg_op`=2 commits the shadow list of `cfg_port`. A port that is not running takes the list on the next edge. A running port takes it at its next cycle boundary, and that boundary begins with entry 0 of the new list.
- R8: `cfg_ready` falls in the cycle after a commit is taken and returns high on the edge where the last pending swap is made.
- R9: When two or more ports have a gate event in the same slot, `sched_conflict` is 1 and `conflict_ports` flags exactly those ports, in the same cycle their gates change. Otherwise both are 0.
- R10: Each port follows only its own list. A port that is never committed keeps all gates open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | TIME_W | Free-running time in ns, non-decreasing |
| base_ns | input | TIME_W | Shared schedule base time in ns |
| cfg_valid | input | 1 | Configuration beat valid |
| cfg_ready | output | 1 | Configuration channel can take a beat |
| cfg_port | input | PIDX_W | Target port of the beat |
| cfg_op | input | 2 | 0 entry, 1 length and cycle, 2 commit, 3 no effect |
| cfg_idx | input | IDX_W | Entry index, or last entry index for op 1 |
| cfg_mask | input | NTC | Class mask for op 0 |
| cfg_ns | input | CFG_NS_W | Interval or cycle time in ns |
| cfg_err | output | 1 | Pulse: a zero-slot write was dropped |
| gate_open | output | NPORTS*NTC | Per-port, per-class gate state |
| sched_conflict | output | 1 | Pulse: gate events of several ports in one slot |
| conflict_ports | output | NPORTS | Ports involved in the conflict |

## Verification
A wrong entry pointer or event time in one port engine shows up as a gate byte that differs from the expected one at the very next event of that port, and the error then lasts until the next cycle boundary. A lost or early swap shows up on the edge of the boundary where the new list should begin, and `cfg_ready` stays in the wrong state from that edge on. A wrong conflict compare shows up on the same edge as the event, so the reference model checks the gates, the ready state, the error pulse and the conflict outputs on every clock.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int unsigned SLOT_NS      = 200;
  localparam int unsigned HALF_SLOT_NS = SLOT_NS / 2;

  typedef enum logic [1:0] {
    OP_ENTRY  = 2'd0,
    OP_SHAPE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_NONE   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/tas_sched_table.sv
// Shadow and active entry lists of one port, with whole-list swap.
module tas_sched_table #(
  parameter int NTC    = 8,
  parameter int NENTRY = 8,
  parameter int IV_W   = 25,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_entry,
  input  logic             wr_shape,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NTC-1:0]   wr_mask,
  input  logic [IV_W-1:0]  wr_slots,
  input  logic             swap,
  input  logic             use_sh,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NTC-1:0]   rd_mask,
  output logic [IV_W-1:0]  rd_iv,
  output logic [IDX_W-1:0] act_last,
  output logic [NTC-1:0]   first_mask,
  output logic [IV_W-1:0]  first_iv,
  output logic [IDX_W-1:0] use_last,
  output logic [IV_W-1:0]  use_cyc
);
  logic [NTC-1:0]   sh_mask [NENTRY];
  logic [IV_W-1:0]  sh_iv   [NENTRY];
  logic [NTC-1:0]   ac_mask [NENTRY];
  logic [IV_W-1:0]  ac_iv   [NENTRY];
  logic [IDX_W-1:0] sh_last, ac_last;
  logic [IV_W-1:0]  sh_cyc, ac_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NENTRY; k++) begin
        sh_mask[k] <= '0;
        sh_iv[k]   <= '0;
        ac_mask[k] <= '0;
        ac_iv[k]   <= '0;
      end
      sh_last <= '0;
      ac_last <= '0;
      sh_cyc  <= '0;
      ac_cyc  <= '0;
    end else begin
      if (wr_entry) begin
        sh_mask[wr_idx] <= wr_mask;
        sh_iv[wr_idx]   <= wr_slots;
      end
      if (wr_shape) begin
        sh_last <= wr_idx;
        sh_cyc  <= wr_slots;
      end
      if (swap) begin
        for (int k = 0; k < NENTRY; k++) begin
          ac_mask[k] <= sh_mask[k];
          ac_iv[k]   <= sh_iv[k];
        end
        ac_last <= sh_last;
        ac_cyc  <= sh_cyc;
      end
    end
  end

  assign rd_mask    = ac_mask[rd_idx];
  assign rd_iv      = ac_iv[rd_idx];
  assign act_last   = ac_last;
  assign first_mask = use_sh ? sh_mask[0] : ac_mask[0];
  assign first_iv   = use_sh ? sh_iv[0]   : ac_iv[0];
  assign use_last   = use_sh ? sh_last    : ac_last;
  assign use_cyc    = use_sh ? sh_cyc     : ac_cyc;
endmodule

// File: rtl/tas_port_engine.sv
// Per-port cycle tracker: start at base, step entries, swap at boundary.
module tas_port_engine #(
  parameter int NTC    = 8,
  parameter int NENTRY = 8,
  parameter int TIME_W = 64,
  parameter int IV_W   = 25,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_ns,
  input  logic [TIME_W-1:0] base_ns,
  input  logic              wr_entry,
  input  logic              wr_shape,
  input  logic              wr_commit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NTC-1:0]    wr_mask,
  input  logic [IV_W-1:0]   wr_slots,
  output logic              pend_o,
  output logic [NTC-1:0]    gates_o,
  output logic              fire_o,
  output logic [TIME_W-1:0] ev_time_o
);
  import tas_pkg::*;

  function automatic logic [TIME_W-1:0] to_ns(input logic [IV_W-1:0] s);
    return TIME_W'(s) * TIME_W'(SLOT_NS);
  endfunction

  logic              have, running, pend;
  logic [IDX_W-1:0]  idx;
  logic [TIME_W-1:0] ee, ce;
  logic [NTC-1:0]    gates;

  logic              fire_start, fire_run, at_bnd, swap;
  logic [IDX_W-1:0]  nidx, act_last, use_last;
  logic [NTC-1:0]    rd_mask, first_mask;
  logic [IV_W-1:0]   rd_iv, first_iv, use_cyc;
  logic [TIME_W-1:0] bnd_s, b_ce, b_first, b_ee, s_first, s_ee;

  tas_sched_table #(
    .NTC(NTC), .NENTRY(NENTRY), .IV_W(IV_W), .IDX_W(IDX_W)
  ) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_entry(wr_entry), .wr_shape(wr_shape), .wr_idx(wr_idx),
    .wr_mask(wr_mask), .wr_slots(wr_slots),
    .swap(swap), .use_sh(pend), .rd_idx(nidx),
    .rd_mask(rd_mask), .rd_iv(rd_iv), .act_last(act_last),
    .first_mask(first_mask), .first_iv(first_iv),
    .use_last(use_last), .use_cyc(use_cyc)
  );

  always_comb begin
    fire_start = !running && have && (time_ns >= base_ns);
    fire_run   = running && (time_ns >= ee);
    at_bnd     = fire_start || (fire_run && (ee == ce));
    swap       = pend && (!running || at_bnd);
    bnd_s      = running ? ce : base_ns;
    b_ce       = bnd_s + to_ns(use_cyc);
    b_first    = bnd_s + to_ns(first_iv);
    b_ee       = ((use_last == '0) || (b_first >= b_ce)) ? b_ce : b_first;
    nidx       = idx + IDX_W'(1);
    s_first    = ee + to_ns(rd_iv);
    s_ee       = ((nidx == act_last) || (s_first >= ce)) ? ce : s_first;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have    <= 1'b0;
      running <= 1'b0;
      pend    <= 1'b0;
      idx     <= '0;
      ee      <= '0;
      ce      <= '0;
      gates   <= '1;
    end else begin
      if (swap) begin
        pend <= 1'b0;
        have <= 1'b1;
      end
      if (wr_commit) pend <= 1'b1;
      if (at_bnd) begin
        running <= 1'b1;
        idx     <= '0;
        ce      <= b_ce;
        ee      <= b_ee;
        gates   <= first_mask;
      end else if (fire_run) begin
        idx   <= nidx;
        ee    <= s_ee;
        gates <= rd_mask;
      end
    end
  end

  assign pend_o    = pend;
  assign gates_o   = gates;
  assign fire_o    = fire_start || fire_run;
  assign ev_time_o = fire_start ? base_ns : ee;
endmodule

// File: rtl/tas_conflict_detect.sv
// Flags every port whose gate event shares its slot with another port.
module tas_conflict_detect #(
  parameter int NPORTS = 4,
  parameter int TIME_W = 64
) (
  input  logic [NPORTS-1:0]             fire,
  input  logic [NPORTS-1:0][TIME_W-1:0] ev_time,
  output logic [NPORTS-1:0]             hit
);
  logic [NPORTS-1:0][NPORTS-1:0] pair;

  for (genvar i = 0; i < NPORTS; i++) begin : g_row
    for (genvar j = 0; j < NPORTS; j++) begin : g_col
      if (i == j) begin : g_self
        assign pair[i][j] = 1'b0;
      end else begin : g_other
        assign pair[i][j] = fire[i] && fire[j] && (ev_time[i] == ev_time[j]);
      end
    end
    assign hit[i] = |pair[i];
  end
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NPORTS   = 4,
  parameter int NTC      = 8,
  parameter int NENTRY   = 8,
  parameter int TIME_W   = 64,
  parameter int CFG_NS_W = 32,
  localparam int PIDX_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int IDX_W   = (NENTRY > 1) ? $clog2(NENTRY) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TIME_W-1:0]     time_ns,
  input  logic [TIME_W-1:0]     base_ns,
  input  logic                  cfg_valid,
  output logic                  cfg_ready,
  input  logic [PIDX_W-1:0]     cfg_port,
  input  logic [1:0]            cfg_op,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [NTC-1:0]        cfg_mask,
  input  logic [CFG_NS_W-1:0]   cfg_ns,
  output logic                  cfg_err,
  output logic [NPORTS*NTC-1:0] gate_open,
  output logic                  sched_conflict,
  output logic [NPORTS-1:0]     conflict_ports
);
  import tas_pkg::*;

  localparam int IV_W = CFG_NS_W - 7;

  logic [CFG_NS_W:0] rnd_sum, rnd_q;
  logic [IV_W-1:0]   slots;
  logic              acc, is_entry, is_shape, is_commit, zero_slots;

  logic [NPORTS-1:0]             pend_vec, fire_vec, hit_vec;
  logic [NPORTS-1:0][TIME_W-1:0] ev_time;

  always_comb begin
    rnd_sum    = {1'b0, cfg_ns} + (CFG_NS_W+1)'(HALF_SLOT_NS);
    rnd_q      = rnd_sum / (CFG_NS_W+1)'(SLOT_NS);
    slots      = IV_W'(rnd_q);
    zero_slots = (slots == '0);
    acc        = cfg_valid && cfg_ready;
    is_entry   = acc && (cfg_op_e'(cfg_op) == OP_ENTRY);
    is_shape   = acc && (cfg_op_e'(cfg_op) == OP_SHAPE);
    is_commit  = acc && (cfg_op_e'(cfg_op) == OP_COMMIT);
  end

  assign cfg_ready = ~|pend_vec;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic sel;
    assign sel = (cfg_port == PIDX_W'(p));

    tas_port_engine #(
      .NTC(NTC), .NENTRY(NENTRY), .TIME_W(TIME_W), .IV_W(IV_W), .IDX_W(IDX_W)
    ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .time_ns(time_ns), .base_ns(base_ns),
      .wr_entry(is_entry && sel && !zero_slots),
      .wr_shape(is_shape && sel && !zero_slots),
      .wr_commit(is_commit && sel),
      .wr_idx(cfg_idx), .wr_mask(cfg_mask), .wr_slots(slots),
      .pend_o(pend_vec[p]),
      .gates_o(gate_open[p*NTC +: NTC]),
      .fire_o(fire_vec[p]),
      .ev_time_o(ev_time[p])
    );
  end

  tas_conflict_detect #(.NPORTS(NPORTS), .TIME_W(TIME_W)) u_cfl (
    .fire(fire_vec), .ev_time(ev_time), .hit(hit_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err        <= 1'b0;
      sched_conflict <= 1'b0;
      conflict_ports <= '0;
    end else begin
      cfg_err        <= (is_entry || is_shape) && zero_slots;
      sched_conflict <= |hit_vec;
      conflict_ports <= hit_vec;
    end
  end
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
  parameter int NPORTS   = 4,
  parameter int CFG_NS_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_valid,
  input logic                cfg_ready,
  input logic [1:0]          cfg_op,
  input logic [CFG_NS_W-1:0] cfg_ns,
  input logic                cfg_err,
  input logic                sched_conflict,
  input logic [NPORTS-1:0]   conflict_ports
);
  logic zero_wr;
  assign zero_wr = cfg_valid && cfg_ready && (cfg_op == 2'd0 || cfg_op == 2'd1)
                   && (cfg_ns < CFG_NS_W'(100));

  a_r6_err_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> cfg_err);
  a_r6_no_stray_err: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_wr |=> !cfg_err);
  a_r8_commit_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_op == 2'd2) |=> !cfg_ready);
  a_r9_two_or_more: assert property (@(posedge clk) disable iff (!rst_n)
    sched_conflict |-> ($countones(conflict_ports) >= 2));
  a_r9_quiet_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_conflict |-> (conflict_ports == '0));
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.NPORTS(NPORTS), .CFG_NS_W(CFG_NS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_op(cfg_op), .cfg_ns(cfg_ns), .cfg_err(cfg_err),
  .sched_conflict(sched_conflict), .conflict_ports(conflict_ports)
);

// File: tb/tb_tas_gate_sched.sv
`timescale 1ns/1ps
module tb_tas_gate_sched;
  localparam int NP = 4;
  localparam int NT = 8;
  localparam int NE = 8;
  localparam longint STEP = 50;
  localparam longint BASE = 10000;
  localparam int WD = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] time_ns = '0;
  logic [63:0] base_ns = 64'(BASE);
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [1:0] cfg_port = '0;
  logic [1:0] cfg_op = '0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_mask = '0;
  logic [31:0] cfg_ns = '0;
  logic cfg_err;
  logic [NP*NT-1:0] gate_open;
  logic sched_conflict;
  logic [NP-1:0] conflict_ports;

  always #2.5 clk = ~clk;

  tas_gate_sched dut (
    .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .base_ns(base_ns),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_port(cfg_port),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .cfg_ns(cfg_ns),
    .cfg_err(cfg_err), .gate_open(gate_open),
    .sched_conflict(sched_conflict), .conflict_ports(conflict_ports)
  );

  int tests = 0, fails = 0, cycles = 0;

  // reference model state
  int sh_mask[NP][NE], sh_iv[NP][NE], sh_last[NP], sh_cyc[NP];
  int a_mask[NP][NE], a_iv[NP][NE], a_last[NP], a_cyc[NP];
  bit have[NP], run[NP], pend[NP];
  longint s0[NP], ps0[NP];
  int pj[NP];
  int exp_gate[NP];
  bit m_ready = 1'b1, m_err = 1'b0, m_cfl = 1'b0;
  int m_cports = 0;

  task automatic check(bit ok, string tag, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at time_ns %0d", tag, act, expv, time_ns);
    end
  endtask

  task automatic copy_list(int p);
    for (int k = 0; k < NE; k++) begin
      a_mask[p][k] = sh_mask[p][k];
      a_iv[p][k] = sh_iv[p][k];
    end
    a_last[p] = sh_last[p];
    a_cyc[p] = sh_cyc[p];
  endtask

  task automatic model_step();
    longint t = longint'(time_ns);
    int evmask = 0, evcnt = 0;
    bit acc;
    for (int p = 0; p < NP; p++) begin
      bit wasrun = run[p];
      if (run[p]) begin
        if (t >= s0[p] + longint'(a_cyc[p]) * 200) begin
          s0[p] += longint'(a_cyc[p]) * 200;
          if (pend[p]) begin copy_list(p); pend[p] = 0; end
        end
      end else begin
        bit startable = have[p] && (t >= BASE);
        if (pend[p]) begin copy_list(p); have[p] = 1; pend[p] = 0; end
        if (startable) begin run[p] = 1; s0[p] = BASE; end
      end
      if (run[p]) begin
        longint off = t - s0[p];
        longint sum = 0;
        int j = a_last[p];
        for (int k = 0; k <= a_last[p]; k++) begin
          sum += longint'(a_iv[p][k]) * 200;
          if (off < sum) begin j = k; break; end
        end
        exp_gate[p] = a_mask[p][j];
        if (!wasrun || s0[p] != ps0[p] || j != pj[p]) begin
          evmask |= (1 << p);
          evcnt++;
        end
        ps0[p] = s0[p];
        pj[p] = j;
      end else begin
        exp_gate[p] = 8'hFF;
      end
    end
    acc = cfg_valid && m_ready;
    m_err = 1'b0;
    if (acc) begin
      int sl = (int'(cfg_ns) + 100) / 200;
      if (cfg_op == 2'd0 || cfg_op == 2'd1) begin
        if (sl == 0) m_err = 1'b1;
        else if (cfg_op == 2'd0) begin
          sh_mask[cfg_port][cfg_idx] = cfg_mask;
          sh_iv[cfg_port][cfg_idx] = sl;
        end else begin
          sh_last[cfg_port] = cfg_idx;
          sh_cyc[cfg_port] = sl;
        end
      end else if (cfg_op == 2'd2) begin
        pend[cfg_port] = 1'b1;
      end
    end
    m_ready = 1'b1;
    for (int p = 0; p < NP; p++) if (pend[p]) m_ready = 1'b0;
    m_cfl = (evcnt >= 2);
    m_cports = m_cfl ? evmask : 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    model_step();
    for (int p = 0; p < NP; p++)
      check(gate_open[p*NT +: NT] == 8'(exp_gate[p]), $sformatf("R1/R2/R3/R4/R5/R7/R10 gates port %0d", p),
            longint'(gate_open[p*NT +: NT]), longint'(exp_gate[p]));
    check(cfg_ready == m_ready, "R8 cfg_ready", longint'(cfg_ready), longint'(m_ready));
    check(cfg_err == m_err, "R6 cfg_err", longint'(cfg_err), longint'(m_err));
    check(sched_conflict == m_cfl, "R9 sched_conflict", longint'(sched_conflict), longint'(m_cfl));
    check(conflict_ports == 4'(m_cports), "R9 conflict_ports", longint'(conflict_ports), longint'(m_cports));
    time_ns = time_ns + 64'(STEP);
    if (cycles > WD) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WD);
      finish_run();
    end
  endtask

  task automatic send(int port, int op, int idx, int mask, int ns);
    bit was;
    cfg_valid = 1'b1;
    cfg_port = 2'(port);
    cfg_op = 2'(op);
    cfg_idx = 3'(idx);
    cfg_mask = 8'(mask);
    cfg_ns = 32'(ns);
    do begin
      was = m_ready;
      tick();
    end while (!was);
    cfg_valid = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < NE; k++) begin
        sh_mask[p][k] = 0; sh_iv[p][k] = 0; a_mask[p][k] = 0; a_iv[p][k] = 0;
      end
      sh_last[p] = 0; sh_cyc[p] = 0; a_last[p] = 0; a_cyc[p] = 0;
      have[p] = 0; run[p] = 0; pend[p] = 0; s0[p] = 0; ps0[p] = 0; pj[p] = 0;
      exp_gate[p] = 8'hFF;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(gate_open == '1, "R1 reset gates", longint'(gate_open), 64'hFFFF_FFFF);
    check(cfg_ready == 1'b1, "R1 reset cfg_ready", longint'(cfg_ready), 1);
    check(cfg_err == 1'b0 && sched_conflict == 1'b0 && conflict_ports == '0,
          "R1 reset flags", longint'({cfg_err, sched_conflict, conflict_ports}), 0);

    // port 0: class 7 for 2 slots, classes 0..6 for 3 slots, cycle 5 slots
    send(0, 0, 0, 8'h80, 400);
    send(0, 0, 1, 8'h7F, 600);
    send(0, 0, 1, 8'h55, 60);            // R6: rounds to zero, dropped
    check(cfg_err == 1'b1, "R6 zero-slot entry flagged", longint'(cfg_err), 1);
    send(0, 1, 1, 0, 1000);
    // port 1: rounding 250->1, 299->1, 1100->6; last entry extends (R4, R5)
    send(1, 0, 0, 8'h01, 250);
    send(1, 0, 1, 8'h02, 299);
    send(1, 1, 1, 0, 1100);
    // port 2: sum exceeds cycle, entry 2 never shown (R4)
    send(2, 0, 0, 8'h0F, 300);
    send(2, 0, 1, 8'hF0, 500);
    send(2, 0, 2, 8'hAA, 600);
    send(2, 1, 2, 0, 1000);
    send(2, 1, 0, 0, 10);                // R6: zero cycle dropped
    check(cfg_err == 1'b1, "R6 zero-slot cycle flagged", longint'(cfg_err), 1);
    send(0, 3, 0, 0, 0);                 // op 3: no effect
    send(0, 2, 0, 0, 0);
    check(cfg_ready == 1'b0, "R8 ready low after commit", longint'(cfg_ready), 0);
    send(1, 2, 0, 0, 0);
    send(2, 2, 0, 0, 0);
    check(gate_open == '1, "R1 open before base", longint'(gate_open), 64'hFFFF_FFFF);

    while (longint'(time_ns) < BASE + 4000) tick();

    // R7: live reconfiguration of port 1 at its boundary
    send(1, 0, 0, 8'h33, 400);
    send(1, 2, 0, 0, 0);
    check(cfg_ready == 1'b0, "R8 ready held during pending swap", longint'(cfg_ready), 0);
    while (!m_ready) tick();
    check(gate_open[NT +: NT] == 8'h33, "R7 new list at boundary", longint'(gate_open[NT +: NT]), 8'h33);

    while (longint'(time_ns) < BASE + 9000) tick();
    check(gate_open[3*NT +: NT] == 8'hFF, "R10 uncommitted port open", longint'(gate_open[3*NT +: NT]), 8'hFF);
    finish_run();
  end
endmodule